// File: doc/BRIEF.md
# Flash Command Interface Controller

This block decodes the command bus of a byte-wide NOR-style flash device and runs its write state machine. Bus cycles are sampled on the clock. A write cycle has chip enable and write enable both low. A read cycle has chip enable and output enable low with write enable high. Commands take one or two write cycles. The active read mode decides whether a read returns the array, the status register or the identifier codes.

Program, erase and lock-bit operations are timed by a down-counter. An erase or program can be suspended and resumed. Block and master lock bits protect the array and the lock configuration. Error flags in the status register stay set until software clears them. The array is a small internal register model that reset does not touch. Lock bits are held in resettable registers.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read mode is array. Writing FFh selects array mode. A read returns the byte stored at `addr` one clock after the read cycle is sampled.
- R2: Program is 40h or 10h, then a second cycle that carries the target address and data. The stored byte becomes old AND new. The operation takes PROG_CYC cycles, and afterwards the read mode is status.
- R3: Erase is 20h, then D0h on an address inside the block. When it completes, every byte of that block (`addr[ADDR_W-1 -: BLK_W]`) reads FFh.
- R4: Status bit 7 is 1 when the state machine is ready and 0 while an operation is running. Bit 0 always reads 0. A read cycle sets `dout_en` on the next clock.
- R5: B0h during a running erase or program halts it. Status then reads 80h plus 40h for a suspended erase, or plus 04h for a suspended program, and array reads are allowed. D0h resumes the operation, which then completes. B0h while idle has no effect.
- R6: A second cycle after 20h that is not D0h, or after 60h that is not 01h, F1h or D0h, sets status bits 5 and 4 and starts nothing.
- R7: Starting program or erase while `vpp_ok` is low sets status bits 4 and 3 and leaves the array unchanged.
- R8: 60h then 01h sets the lock of the addressed block. Program or erase of a locked block is refused while `lock_override` is low: bit 1 is set together with bit 4 (program) or bit 5 (erase). With the override high the operation proceeds.
- R9: 60h then F1h sets the master lock. 60h then D0h clears all block locks. While the master lock is set and the override is low, a lock change is refused: bit 1 is set together with bit 4 (set) or bit 5 (clear), and the locks are unchanged.
- R10: Status bits 5, 4, 3 and 1 stay set across other commands until 50h is written.
- R11: After 90h, a read at `addr[1:0]`=0 returns MFR_ID and 1 returns DEV_ID. Offset 2 returns 01h or 00h for the addressed block's lock. Offset 3 returns 01h or 00h for the master lock.
- R12: Reset during an operation aborts it. The array keeps its previous contents and status reads 80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset and deep power-down |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Command or data byte |
| dout | output | 8 | Read data, registered |
| dout_en | output | 1 | Read data valid, registered |
| vpp_ok | input | 1 | Programming voltage valid |
| lock_override | input | 1 | Permits changes that a lock would refuse |

## Verification
Programming is tried with both setup codes. A repeated program to the same byte shows AND behaviour rather than overwrite. Erase is run on locked and unlocked blocks, with and without the override, and with the programming voltage off, so each refusal path is distinguished by its own status code. Suspend is applied to both an erase and a program: the array read in the suspended state shows the operation really stopped, and the read after resume shows it finished. Invalid second cycles and a mid-operation reset separate the sequence-error path from the abort path.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SET_PROG, ST_SET_ERASE, ST_SET_LOCK, ST_BUSY, ST_SUSP
  } seq_st_e;

  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT} rd_mode_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_PROG, OP_ERASE, OP_LK_BLK, OP_LK_MST, OP_UNLK
  } op_e;

  localparam logic [DW-1:0] C_RD_ARRAY = 8'hFF;
  localparam logic [DW-1:0] C_RD_STAT  = 8'h70;
  localparam logic [DW-1:0] C_CLR_STAT = 8'h50;
  localparam logic [DW-1:0] C_IDENT    = 8'h90;
  localparam logic [DW-1:0] C_PROG_A   = 8'h40;
  localparam logic [DW-1:0] C_PROG_B   = 8'h10;
  localparam logic [DW-1:0] C_ERASE    = 8'h20;
  localparam logic [DW-1:0] C_LOCK     = 8'h60;
  localparam logic [DW-1:0] C_CONFIRM  = 8'hD0;
  localparam logic [DW-1:0] C_SUSPEND  = 8'hB0;
  localparam logic [DW-1:0] C_LK_BLK   = 8'h01;
  localparam logic [DW-1:0] C_LK_MST   = 8'hF1;

  // error flag vector positions
  localparam int E_ERS = 3;  // status bit 5
  localparam int E_PRG = 2;  // status bit 4
  localparam int E_VPP = 1;  // status bit 3
  localparam int E_LCK = 0;  // status bit 1
endpackage

// File: rtl/flc_timer.sv
module flc_timer #(
  parameter int ERASE_CYC = 30,
  parameter int PROG_CYC  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_sel,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(ERASE_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = long_sel ? CW'(ERASE_CYC) : CW'(PROG_CYC);
    else if (run && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  assign done = run && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  tmr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q > CW'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/flc_store.sv
module flc_store
  import flc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BLK_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  op_e               op,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DW-1:0]     op_data,
  input  logic [ADDR_W-1:0] look_addr,
  output logic [DW-1:0]     look_byte,
  output logic              look_lock,
  output logic              master
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NBLK  = 1 << BLK_W;
  localparam int OFF_W = ADDR_W - BLK_W;

  logic [DW-1:0]    cells [DEPTH];
  logic [BLK_W-1:0] op_blk;
  logic [NBLK-1:0]  blk_lock_q, blk_lock_d;
  logic             master_q, master_d;

  assign op_blk = op_addr[ADDR_W-1:OFF_W];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam logic [ADDR_W-1:0] GA = ADDR_W'(g);
    logic [DW-1:0] cell_q;
    logic          hit_erase, hit_prog;
    assign hit_erase = commit && (op == OP_ERASE) && (op_blk == GA[ADDR_W-1:OFF_W]);
    assign hit_prog  = commit && (op == OP_PROG) && (op_addr == GA);
    always_ff @(posedge clk) begin
      if (hit_erase)     cell_q <= '1;
      else if (hit_prog) cell_q <= cell_q & op_data;
    end
    assign cells[g] = cell_q;
  end

  always_comb begin
    blk_lock_d = blk_lock_q;
    master_d   = master_q;
    if (commit) begin
      case (op)
        OP_LK_BLK: blk_lock_d[op_blk] = 1'b1;
        OP_LK_MST: master_d = 1'b1;
        OP_UNLK:   blk_lock_d = '0;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_lock_q <= '0;
      master_q   <= 1'b0;
    end else begin
      blk_lock_q <= blk_lock_d;
      master_q   <= master_d;
    end
  end

  assign look_byte = cells[look_addr];
  assign look_lock = blk_lock_q[look_addr[ADDR_W-1:OFF_W]];
  assign master    = master_q;

  // R3
  erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && op == OP_ERASE) |=> (cells[$past(op_addr)] == 8'hFF));
endmodule

// File: rtl/flc_seq.sv
module flc_seq
  import flc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     din,
  input  logic              vpp_ok,
  input  logic              lock_ovr,
  input  logic              blk_locked,
  input  logic              master,
  input  logic              t_done,
  output logic              t_load,
  output logic              t_long,
  output logic              t_run,
  output logic              commit,
  output op_e               op,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DW-1:0]     op_data,
  output rd_mode_e          rmode,
  output logic [DW-1:0]     status
);
  seq_st_e           st_q, st_d;
  rd_mode_e          rm_q, rm_d;
  op_e               op_q, op_d, req;
  logic [ADDR_W-1:0] oa_q, oa_d;
  logic [DW-1:0]     od_q, od_d;
  logic [3:0]        err_q, err_d;
  logic              start_ok;

  always_comb begin
    st_d     = st_q;
    rm_d     = rm_q;
    op_d     = op_q;
    oa_d     = oa_q;
    od_d     = od_q;
    err_d    = err_q;
    req      = OP_NONE;
    t_load   = 1'b0;
    commit   = 1'b0;
    start_ok = 1'b0;

    if (st_q == ST_BUSY && t_done) begin
      commit = 1'b1;
      st_d   = ST_IDLE;
    end else if (wr_stb) begin
      case (st_q)
        ST_IDLE: begin
          case (din)
            C_RD_ARRAY: rm_d = RM_ARRAY;
            C_RD_STAT:  rm_d = RM_STATUS;
            C_IDENT:    rm_d = RM_IDENT;
            C_CLR_STAT: err_d = '0;
            C_PROG_A, C_PROG_B: begin st_d = ST_SET_PROG;  rm_d = RM_STATUS; end
            C_ERASE:            begin st_d = ST_SET_ERASE; rm_d = RM_STATUS; end
            C_LOCK:             begin st_d = ST_SET_LOCK;  rm_d = RM_STATUS; end
            default: ;
          endcase
        end
        ST_SET_PROG:  req = OP_PROG;
        ST_SET_ERASE: begin
          if (din == C_CONFIRM) req = OP_ERASE;
          else begin
            err_d[E_ERS] = 1'b1;
            err_d[E_PRG] = 1'b1;
            st_d = ST_IDLE;
          end
        end
        ST_SET_LOCK: begin
          case (din)
            C_LK_BLK:  req = OP_LK_BLK;
            C_LK_MST:  req = OP_LK_MST;
            C_CONFIRM: req = OP_UNLK;
            default: begin
              err_d[E_ERS] = 1'b1;
              err_d[E_PRG] = 1'b1;
              st_d = ST_IDLE;
            end
          endcase
        end
        ST_BUSY: begin
          if (din == C_SUSPEND && (op_q == OP_PROG || op_q == OP_ERASE)) st_d = ST_SUSP;
          else if (din == C_RD_STAT) rm_d = RM_STATUS;
        end
        ST_SUSP: begin
          case (din)
            C_CONFIRM:  begin st_d = ST_BUSY; rm_d = RM_STATUS; end
            C_RD_ARRAY: rm_d = RM_ARRAY;
            C_RD_STAT:  rm_d = RM_STATUS;
            C_IDENT:    rm_d = RM_IDENT;
            default: ;
          endcase
        end
        default: st_d = ST_IDLE;
      endcase

      if (req != OP_NONE) begin
        st_d = ST_IDLE;
        oa_d = addr;
        od_d = din;
        if (!vpp_ok) begin
          err_d[E_VPP] = 1'b1;
          err_d[E_PRG] = 1'b1;
        end else if ((req == OP_PROG || req == OP_ERASE) && blk_locked && !lock_ovr) begin
          err_d[E_LCK] = 1'b1;
          if (req == OP_ERASE) err_d[E_ERS] = 1'b1;
          else                 err_d[E_PRG] = 1'b1;
        end else if ((req == OP_LK_BLK || req == OP_LK_MST || req == OP_UNLK) &&
                     master && !lock_ovr) begin
          err_d[E_LCK] = 1'b1;
          if (req == OP_UNLK) err_d[E_ERS] = 1'b1;
          else                err_d[E_PRG] = 1'b1;
        end else begin
          start_ok = 1'b1;
          st_d     = ST_BUSY;
          op_d     = req;
          t_load   = 1'b1;
        end
      end
    end
  end

  assign t_long = (op_d == OP_ERASE);
  assign t_run  = (st_q == ST_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rm_q  <= RM_ARRAY;
      op_q  <= OP_NONE;
      oa_q  <= '0;
      od_q  <= '0;
      err_q <= '0;
    end else begin
      st_q  <= st_d;
      rm_q  <= rm_d;
      op_q  <= op_d;
      err_q <= err_d;
      if (wr_stb) begin
        oa_q <= oa_d;
        od_q <= od_d;
      end
    end
  end

  assign op      = op_q;
  assign op_addr = oa_q;
  assign op_data = od_q;
  assign rmode   = rm_q;
  assign status  = {st_q != ST_BUSY,
                    (st_q == ST_SUSP) && (op_q == OP_ERASE),
                    err_q[E_ERS], err_q[E_PRG], err_q[E_VPP],
                    (st_q == ST_SUSP) && (op_q == OP_PROG),
                    err_q[E_LCK], 1'b0};

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && st_q == ST_IDLE && din == C_CLR_STAT)
      |=> ((err_q & $past(err_q)) == $past(err_q)));

  // R8
  blk_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && (op_d == OP_PROG || op_d == OP_ERASE)) |-> (!blk_locked || lock_ovr));

  // R9
  mst_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && st_q == ST_SET_LOCK) |-> (!master || lock_ovr));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flc_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          BLK_W     = 2,
  parameter int          ERASE_CYC = 30,
  parameter int          PROG_CYC  = 8,
  parameter logic [7:0]  MFR_ID    = 8'hB4,
  parameter logic [7:0]  DEV_ID    = 8'h6E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  input  logic              vpp_ok,
  input  logic              lock_override
);
  logic              wr_stb, rd_req;
  logic              t_load, t_long, t_run, t_done, commit;
  op_e               op;
  logic [ADDR_W-1:0] op_addr;
  logic [DW-1:0]     op_data, status, look_byte, rd_val;
  logic              look_lock, master;
  rd_mode_e          rmode;

  assign wr_stb = !ce_n && !we_n;
  assign rd_req = !ce_n && !oe_n && we_n;

  flc_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(addr), .din(din),
    .vpp_ok(vpp_ok), .lock_ovr(lock_override), .blk_locked(look_lock),
    .master(master), .t_done(t_done), .t_load(t_load), .t_long(t_long),
    .t_run(t_run), .commit(commit), .op(op), .op_addr(op_addr),
    .op_data(op_data), .rmode(rmode), .status(status)
  );

  flc_timer #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(t_load), .long_sel(t_long),
    .run(t_run), .done(t_done)
  );

  flc_store #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit), .op(op), .op_addr(op_addr),
    .op_data(op_data), .look_addr(addr), .look_byte(look_byte),
    .look_lock(look_lock), .master(master)
  );

  always_comb begin
    case (rmode)
      RM_STATUS: rd_val = status;
      RM_IDENT: begin
        case (addr[1:0])
          2'd0:    rd_val = MFR_ID;
          2'd1:    rd_val = DEV_ID;
          2'd2:    rd_val = {7'd0, look_lock};
          default: rd_val = {7'd0, master};
        endcase
      end
      default:   rd_val = look_byte;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout_en <= rd_req;
      if (rd_req) dout <= rd_val;
    end
  end

  // R4
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> dout_en);
endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [7:0] addr = '0, din = '0;
  logic [7:0] dout;
  logic       dout_en;
  logic       vpp_ok = 1'b1, lock_override = 1'b0;

  int vectors = 0, fails = 0;

  typedef struct {
    logic [7:0] e;
    logic [7:0] m;
    bit         chk;
    string      tag;
  } exp_t;
  exp_t sbq[$];

  always #4 clk = ~clk;

  flash_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .vpp_ok(vpp_ok), .lock_override(lock_override)
  );

  // monitor: pops expected items as read data appears
  always @(negedge clk) begin
    if (rst_n && dout_en) begin
      if (sbq.size() == 0) begin
        fails++;
        $display("FAIL unexpected read data: actual %02h expected none", dout);
      end else begin
        exp_t it;
        it = sbq.pop_front();
        if (it.chk) begin
          vectors++;
          if ((dout & it.m) !== (it.e & it.m))
            begin
              fails++;
              $display("FAIL %s: actual %02h expected %02h (mask %02h)",
                       it.tag, dout, it.e, it.m);
            end
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e,
                    input logic [7:0] m, input string tag);
    exp_t it;
    it.e = e; it.m = m; it.chk = 1'b1; it.tag = tag;
    sbq.push_back(it);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic poll_ready(input string tag);
    exp_t it;
    logic [7:0] v;
    bit ok = 1'b0;
    it.e = '0; it.m = '0; it.chk = 1'b0; it.tag = tag;
    for (int i = 0; i < 200; i++) begin
      sbq.push_back(it);
      ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      @(posedge clk); #1;
      v = dout;
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
      if (v[7]) begin ok = 1'b1; break; end
    end
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual busy expected ready", tag);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R4 reset state of status
    wr(8'h00, 8'h70); rd(8'h00, 8'h80, 8'hFF, "R4 status after reset");
    // R5 suspend while idle ignored
    wr(8'h00, 8'hB0); rd(8'h00, 8'h80, 8'hFF, "R5 idle suspend ignored");

    // R11 identifier codes
    wr(8'h00, 8'h90);
    rd(8'h00, 8'hB4, 8'hFF, "R11 mfr");
    rd(8'h01, 8'h6E, 8'hFF, "R11 dev");
    rd(8'h02, 8'h00, 8'hFF, "R11 blk lock clear");
    rd(8'h03, 8'h00, 8'hFF, "R11 master clear");

    // R3 erase block 0, R4 busy
    wr(8'h00, 8'h20); wr(8'h00, 8'hD0);
    rd(8'h00, 8'h00, 8'h80, "R4 busy during erase");
    poll_ready("R3 erase done");
    rd(8'h00, 8'h80, 8'hFF, "R3 status clean");
    wr(8'h00, 8'hFF);
    rd(8'h10, 8'hFF, 8'hFF, "R3 erased byte");
    rd(8'h3F, 8'hFF, 8'hFF, "R3 erased last byte");

    // R2 program with both setup codes, AND behaviour
    wr(8'h10, 8'h40); wr(8'h10, 8'h5A);
    rd(8'h00, 8'h00, 8'h81, "R2 busy after program");
    poll_ready("R2 program done");
    rd(8'h00, 8'h80, 8'hFF, "R2 status mode after program");
    wr(8'h00, 8'hFF); rd(8'h10, 8'h5A, 8'hFF, "R2 programmed byte");
    wr(8'h10, 8'h10); wr(8'h10, 8'h0F);
    poll_ready("R2 second program");
    wr(8'h00, 8'hFF); rd(8'h10, 8'h0A, 8'hFF, "R2 AND of data");

    // R6 sequence errors, R10 stickiness
    wr(8'h00, 8'h20); wr(8'h00, 8'h33);
    rd(8'h00, 8'hB0, 8'hFF, "R6 bad erase confirm");
    wr(8'h00, 8'hFF); wr(8'h00, 8'h70);
    rd(8'h00, 8'hB0, 8'hFF, "R10 error still set");
    wr(8'h00, 8'h50);
    rd(8'h00, 8'h80, 8'hFF, "R10 cleared by 50h");
    wr(8'h00, 8'h60); wr(8'h00, 8'h77);
    rd(8'h00, 8'hB0, 8'hFF, "R6 bad lock code");
    wr(8'h00, 8'h50);

    // R7 programming voltage invalid
    vpp_ok = 1'b0;
    wr(8'h11, 8'h40); wr(8'h11, 8'h00);
    rd(8'h00, 8'h98, 8'hFF, "R7 vpp error");
    wr(8'h00, 8'h50);
    vpp_ok = 1'b1;
    wr(8'h00, 8'hFF); rd(8'h11, 8'hFF, 8'hFF, "R7 array unchanged");

    // R8 block lock
    wr(8'h40, 8'h60); wr(8'h40, 8'h01);
    poll_ready("R8 set block lock");
    wr(8'h00, 8'h90);
    rd(8'h42, 8'h01, 8'hFF, "R8 block 1 locked");
    rd(8'h02, 8'h00, 8'hFF, "R8 block 0 unlocked");
    wr(8'h40, 8'h20); wr(8'h40, 8'hD0);
    rd(8'h00, 8'hA2, 8'hFF, "R8 erase refused");
    wr(8'h00, 8'h50);
    wr(8'h41, 8'h40); wr(8'h41, 8'h00);
    rd(8'h00, 8'h92, 8'hFF, "R8 program refused");
    wr(8'h00, 8'h50);
    lock_override = 1'b1;
    wr(8'h40, 8'h20); wr(8'h40, 8'hD0);
    poll_ready("R8 override erase");
    rd(8'h00, 8'h80, 8'hFF, "R8 override status");
    wr(8'h00, 8'hFF); rd(8'h41, 8'hFF, 8'hFF, "R8 override erased");
    lock_override = 1'b0;

    // R9 lock clear and master lock
    wr(8'h00, 8'h60); wr(8'h00, 8'hD0);
    poll_ready("R9 clear locks");
    wr(8'h00, 8'h90); rd(8'h42, 8'h00, 8'hFF, "R9 block locks cleared");
    wr(8'h00, 8'h60); wr(8'h00, 8'hF1);
    poll_ready("R9 set master");
    wr(8'h00, 8'h90); rd(8'h03, 8'h01, 8'hFF, "R9 master set");
    wr(8'h80, 8'h60); wr(8'h80, 8'h01);
    rd(8'h00, 8'h92, 8'hFF, "R9 set refused");
    wr(8'h00, 8'h50);
    wr(8'h00, 8'h90); rd(8'h82, 8'h00, 8'hFF, "R9 lock unchanged");
    wr(8'h00, 8'h60); wr(8'h00, 8'hD0);
    rd(8'h00, 8'hA2, 8'hFF, "R9 clear refused");
    wr(8'h00, 8'h50);
    lock_override = 1'b1;
    wr(8'h80, 8'h60); wr(8'h80, 8'h01);
    poll_ready("R9 override set");
    wr(8'h00, 8'h90); rd(8'h82, 8'h01, 8'hFF, "R9 override set");
    wr(8'h00, 8'h60); wr(8'h00, 8'hD0);
    poll_ready("R9 override clear");
    wr(8'h00, 8'h90); rd(8'h82, 8'h00, 8'hFF, "R9 override clear");
    lock_override = 1'b0;

    // R5 erase suspend and resume
    wr(8'h00, 8'h20); wr(8'h00, 8'hD0);
    wr(8'h00, 8'hB0);
    rd(8'h00, 8'hC0, 8'hFF, "R5 erase suspended");
    wr(8'h00, 8'hFF); rd(8'h10, 8'h0A, 8'hFF, "R5 erase halted");
    wr(8'h00, 8'hD0);
    rd(8'h00, 8'h00, 8'h80, "R5 erase resumed busy");
    poll_ready("R5 erase resume done");
    wr(8'h00, 8'hFF); rd(8'h10, 8'hFF, 8'hFF, "R5 erase completed");

    // R5 program suspend and resume
    wr(8'h13, 8'h40); wr(8'h13, 8'h81);
    wr(8'h00, 8'hB0);
    rd(8'h00, 8'h84, 8'hFF, "R5 program suspended");
    wr(8'h00, 8'hFF); rd(8'h13, 8'hFF, 8'hFF, "R5 program halted");
    wr(8'h00, 8'hD0);
    poll_ready("R5 program resume done");
    wr(8'h00, 8'hFF); rd(8'h13, 8'h81, 8'hFF, "R5 program completed");

    // R12 reset aborts erase, R1 array mode after reset
    wr(8'h00, 8'h20); wr(8'h00, 8'hD0);
    repeat (3) @(negedge clk);
    do_reset();
    rd(8'h13, 8'h81, 8'hFF, "R12 R1 array kept, array mode");
    wr(8'h00, 8'h70); rd(8'h00, 8'h80, 8'hFF, "R12 status after abort");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule